// File: doc/BRIEF.md
# Cached-Window Address Remapper

This unit sits on the path from a processor to the external memory bus and rewrites the addresses of cached accesses. Software loads a small bank of remap registers through a 32-bit write port and can read them back. It fills in eight window entries, and each entry redirects one 1 MB slice of the processor address space. The eight slices are the ones whose bits 31:20 run from 0x400 to 0x407. Two fallback fields redirect the whole 256 MB regions with top nibble 0x0 and 0x1. A window hit always takes precedence over a fallback field.

Each presented address gives one registered result one clock later. The result holds the external address and a flag that says whether any remap rule applied. A second flag says whether the offset inside the 256 MB region falls within the bounded translation window. The default window is 0x00400000 bytes.

For example, software can load the value 5 into the nibble-0x1 fallback field. The processor address 0x1234_5678 then leaves the unit as 0x5234_5678. The lower 28 bits are kept unchanged.

Top module: `l1win_remap`

## Requirements
- R1: After reset, every register index 0 to 7 reads 0, and `out_valid` is 0.
- R2: Register index k (0 to 3) holds window entry 2k in bits 13:0 and entry 2k+1 in bits 29:16. Index 4 holds the nibble-0x0 fallback field in bits 5:0 and the nibble-0x1 field in bits 13:8. Bits outside these fields read 0. Indexes 5 to 7 read 0, and a write to them changes no register and no translation.
- R3: When input address bits 31:20 equal 0x400+i (i = 0 to 7), the output address is the low 12 bits of entry i followed by input bits 19:0, and `out_remapped` is 1.
- R4: When no window matches and input bits 31:28 are 0x0 (or 0x1), output bits 31:28 are the low 4 bits of the nibble-0x0 (or nibble-0x1) field, and bits 27:0 are copied from the input. `out_remapped` is 1 even if the field repeats the input nibble.
- R5: Any other address, including 0x408xxxxx and 0x3FFxxxxx, passes through unchanged with `out_remapped` 0.
- R6: `out_in_window` is 1 exactly when input bits 27:0 are below 0x00400000. An offset equal to that size gives 0.
- R7: Each cycle with `in_valid` high produces exactly one result with `out_valid` high on the next cycle, using the registers in effect when the address was presented. Back-to-back inputs give back-to-back results, and `out_valid` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Word index of the register written |
| reg_wdata | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Word index of the register read |
| reg_rdata | output | 32 | Read data for `reg_rd_idx` (combinational) |
| in_valid | input | 1 | Processor address present |
| in_addr | input | 32 | Processor-side address |
| out_valid | output | 1 | Translated result present |
| out_addr | output | 32 | External bus address |
| out_remapped | output | 1 | A window or fallback rule applied |
| out_in_window | output | 1 | Region offset lies within the translation window |

## Verification
Each of the eight window entries gets a distinct value, so a wrong entry selected by the index decode shows up as a wrong top field. Addresses just outside the window range (0x3FF and 0x408 in bits 31:20) separate a correct range match from one bit too wide or too narrow. The two fallback nibbles are loaded with different values, which catches swapped fields, and writes carry ones in the unused bits to check masking. The window flag is probed at offsets 0x3FFFFF and 0x400000, and unbroken input streams followed by gaps test the one-cycle result timing.

// File: rtl/l1win_pkg.sv
package l1win_pkg;
    typedef struct packed {
        logic [31:0] addr;
        logic        remapped;
        logic        in_window;
    } xlate_res_t;

    localparam int ADDR_W   = 32;
    localparam int WIN_LSB  = 20;
    localparam int NIB_LSB  = 28;
endpackage

// File: rtl/l1win_regs.sv
module l1win_regs #(
    parameter int N_WIN   = 8,
    parameter int ENTRY_W = 14,
    parameter int FB_W    = 6,
    parameter int REG_AW  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [REG_AW-1:0]             wr_idx,
    input  logic [31:0]                   wdata,
    input  logic [REG_AW-1:0]             rd_idx,
    output logic [31:0]                   rdata,
    output logic [N_WIN-1:0][ENTRY_W-1:0] win_tbl,
    output logic [FB_W-1:0]               fb_lo,
    output logic [FB_W-1:0]               fb_hi
);
    localparam int N_PAIR    = N_WIN / 2;
    localparam int ODD_LSB   = 16;
    localparam int FBHI_LSB  = 8;
    localparam logic [REG_AW-1:0] FB_IDX = REG_AW'(N_PAIR);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_tbl[2*p]   <= '0;
                win_tbl[2*p+1] <= '0;
            end else if (we && wr_idx == REG_AW'(p)) begin
                win_tbl[2*p]   <= wdata[ENTRY_W-1:0];
                win_tbl[2*p+1] <= wdata[ODD_LSB +: ENTRY_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_lo <= '0;
            fb_hi <= '0;
        end else if (we && wr_idx == FB_IDX) begin
            fb_lo <= wdata[FB_W-1:0];
            fb_hi <= wdata[FBHI_LSB +: FB_W];
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            if (rd_idx == REG_AW'(p)) begin
                rdata[ENTRY_W-1:0]          = win_tbl[2*p];
                rdata[ODD_LSB +: ENTRY_W]   = win_tbl[2*p+1];
            end
        end
        if (rd_idx == FB_IDX) begin
            rdata[FB_W-1:0]        = fb_lo;
            rdata[FBHI_LSB +: FB_W] = fb_hi;
        end
    end
endmodule

// File: rtl/l1win_xlate.sv
module l1win_xlate
    import l1win_pkg::*;
#(
    parameter int          N_WIN     = 8,
    parameter int          ENTRY_W   = 14,
    parameter int          FB_W      = 6,
    parameter logic [11:0] WIN_BASE  = 12'h400,
    parameter logic [31:0] WIN_BYTES = 32'h0040_0000
) (
    input  logic [31:0]                   addr,
    input  logic [N_WIN-1:0][ENTRY_W-1:0] win_tbl,
    input  logic [FB_W-1:0]               fb_lo,
    input  logic [FB_W-1:0]               fb_hi,
    output xlate_res_t                    res
);
    localparam int TOP_W = ADDR_W - WIN_LSB;
    localparam int NIB_W = ADDR_W - NIB_LSB;

    logic [N_WIN-1:0] hit;
    logic             unused_fields;
    assign unused_fields = ^{win_tbl, fb_lo, fb_hi};

    for (genvar i = 0; i < N_WIN; i++) begin : g_match
        localparam logic [TOP_W-1:0] SLOT = TOP_W'(WIN_BASE + 12'(i));
        assign hit[i] = (addr[ADDR_W-1:WIN_LSB] == SLOT);
    end

    always_comb begin
        res.addr      = addr;
        res.remapped  = 1'b0;
        res.in_window = ({{NIB_W{1'b0}}, addr[NIB_LSB-1:0]} < WIN_BYTES);
        if (|hit) begin
            res.remapped = 1'b1;
            for (int i = 0; i < N_WIN; i++) begin
                if (hit[i]) res.addr[ADDR_W-1:WIN_LSB] = win_tbl[i][TOP_W-1:0];
            end
        end else if (addr[ADDR_W-1:NIB_LSB] == NIB_W'(0)) begin
            res.remapped = 1'b1;
            res.addr[ADDR_W-1:NIB_LSB] = fb_lo[NIB_W-1:0];
        end else if (addr[ADDR_W-1:NIB_LSB] == NIB_W'(1)) begin
            res.remapped = 1'b1;
            res.addr[ADDR_W-1:NIB_LSB] = fb_hi[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/l1win_remap.sv
module l1win_remap
    import l1win_pkg::*;
#(
    parameter int          N_WIN     = 8,
    parameter int          ENTRY_W   = 14,
    parameter int          FB_W      = 6,
    parameter logic [11:0] WIN_BASE  = 12'h400,
    parameter logic [31:0] WIN_BYTES = 32'h0040_0000,
    localparam int         REG_AW    = $clog2(N_WIN / 2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_wr_idx,
    input  logic [31:0]       reg_wdata,
    input  logic [REG_AW-1:0] reg_rd_idx,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    output logic [31:0]       out_addr,
    output logic              out_remapped,
    output logic              out_in_window
);
    logic [N_WIN-1:0][ENTRY_W-1:0] win_tbl;
    logic [FB_W-1:0]               fb_lo;
    logic [FB_W-1:0]               fb_hi;
    xlate_res_t                    comb_res;

    l1win_regs #(
        .N_WIN(N_WIN), .ENTRY_W(ENTRY_W), .FB_W(FB_W), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wr_idx(reg_wr_idx),
        .wdata(reg_wdata), .rd_idx(reg_rd_idx), .rdata(reg_rdata),
        .win_tbl(win_tbl), .fb_lo(fb_lo), .fb_hi(fb_hi)
    );

    l1win_xlate #(
        .N_WIN(N_WIN), .ENTRY_W(ENTRY_W), .FB_W(FB_W),
        .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_xlate (
        .addr(in_addr), .win_tbl(win_tbl), .fb_lo(fb_lo), .fb_hi(fb_hi),
        .res(comb_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_addr      <= '0;
            out_remapped  <= 1'b0;
            out_in_window <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr      <= comb_res.addr;
                out_remapped  <= comb_res.remapped;
                out_in_window <= comb_res.in_window;
            end
        end
    end
endmodule

// File: rtl/l1win_remap_chk.sv
module l1win_remap_chk #(
    parameter logic [31:0] WIN_BYTES = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_addr,
    input logic        out_valid,
    input logic [31:0] out_addr,
    input logic        out_remapped,
    input logic        out_in_window
);
    // R7: one result per presented address, one cycle later
    assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5: an unremapped result carries the presented address
    assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_remapped) |-> out_addr == $past(in_addr));
    // R3: low 20 bits survive every translation
    assert_low_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[19:0] == $past(in_addr[19:0]));
    // R6: window flag agrees with the presented offset
    assert_window_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_in_window == ({4'h0, $past(in_addr[27:0])} < WIN_BYTES));
endmodule

bind l1win_remap l1win_remap_chk #(.WIN_BYTES(WIN_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_remapped(out_remapped),
    .out_in_window(out_in_window)
);

// File: tb/test_l1win_remap.sv
module test_l1win_remap;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] a;
        logic        r;
        logic        w;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_wr_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rd_idx = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_remapped;
    logic        out_in_window;

    int total = 0;
    int bad = 0;
    exp_t sb[$];
    logic [13:0] sh_ent [8];
    logic [5:0]  sh_lo = '0;
    logic [5:0]  sh_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l1win_remap i_l1win_remap (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wr_idx(reg_wr_idx),
        .reg_wdata(reg_wdata), .reg_rd_idx(reg_rd_idx), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
        .out_addr(out_addr), .out_remapped(out_remapped),
        .out_in_window(out_in_window)
    );

    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t e;
        e.a = a; e.r = 1'b0; e.tag = tag;
        e.w = (a[27:0] < 28'h040_0000);
        if (a[31:23] == 9'h080) begin
            e.a[31:20] = sh_ent[a[22:20]][11:0]; e.r = 1'b1;
        end else if (a[31:28] == 4'h0) begin
            e.a[31:28] = sh_lo[3:0]; e.r = 1'b1;
        end else if (a[31:28] == 4'h1) begin
            e.a[31:28] = sh_hi[3:0]; e.r = 1'b1;
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wr_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (idx < 3'd4) begin
            sh_ent[2*idx]   = d[13:0];
            sh_ent[2*idx+1] = d[29:16];
        end else if (idx == 3'd4) begin
            sh_lo = d[5:0]; sh_hi = d[13:8];
        end
    endtask

    task automatic reg_read_check(input string req, input logic [2:0] idx, input logic [31:0] exp);
        reg_rd_idx = idx;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic drive(input logic [31:0] a, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        sb.push_back(model(a, tag));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares each result against the queued expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 actual=unexpected result %h expected=no result", out_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {out_addr}, e.a);
                check(e.tag, {31'b0, out_remapped}, {31'b0, e.r});
                check("R6", {31'b0, out_in_window}, {31'b0, e.w});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) sh_ent[i] = '0;
        #(CLK_PERIOD * 3);
        // R1: reset state
        for (int i = 0; i < 8; i++) reg_read_check("R1", 3'(i), 32'h0);
        check("R1", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        // R4: with zero fields, both fallback nibbles map to 0
        drive(32'h1234_5678, "R4");
        drive(32'h0ABC_DEF0, "R4");
        idle(2);
        // R2: fallback register with junk in unused bits
        reg_write(3'd4, 32'hABCD_C5C3);
        reg_read_check("R2", 3'd4, 32'h0000_0503);
        // R2: window pairs, unused bits set
        for (int p = 0; p < 4; p++) begin
            logic [13:0] ev, od;
            ev = 14'h2900 + 14'(2*p);
            od = 14'h2900 + 14'(2*p+1);
            reg_write(3'(p), {2'b11, od, 2'b11, ev});
        end
        for (int p = 0; p < 4; p++)
            reg_read_check("R2", 3'(p), {2'b00, 14'h2900 + 14'(2*p+1), 2'b00, 14'h2900 + 14'(2*p)});
        // R3: every window, back-to-back (R7)
        for (int i = 0; i < 8; i++)
            drive({12'h400 + 12'(i), 20'hA5A5A - 20'(i)}, "R3");
        // R4: fallback nibbles, 0x1 maps to 0x5
        drive(32'h1234_5678, "R4");
        drive(32'h0ABC_DEF0, "R4");
        idle(1);
        // R6: window boundary
        drive(32'h103F_FFFF, "R6");
        drive(32'h1040_0000, "R6");
        drive(32'h4000_0000, "R6");
        idle(2);
        // R5: pass-through, including neighbours of the window range
        drive(32'h4080_0000, "R5");
        drive(32'h3FF0_0001, "R5");
        drive(32'hFFFF_FFFF, "R5");
        drive(32'h2000_0000, "R5");
        idle(3);
        // R2: writes to unused index are ignored
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_write(3'd7, 32'hFFFF_FFFF);
        reg_read_check("R2", 3'd5, 32'h0);
        reg_read_check("R2", 3'd7, 32'h0);
        reg_read_check("R2", 3'd4, 32'h0000_0503);
        reg_read_check("R2", 3'd0, {2'b00, 14'h2901, 2'b00, 14'h2900});
        drive(32'h4070_0001, "R2");
        drive(32'h0000_0010, "R2");
        idle(4);
        // R7: nothing left pending
        check("R7", 32'(sb.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule